// File: doc/BRIEF.md
# AGC Power Detector Filter

This block estimates the power of a sampled signal for an automatic gain control loop. Every clock it takes a 14-bit signed sample and keeps only its upper ten bits. It rectifies that slice to a magnitude, and it saturates the single most negative code so that the magnitude fits in nine bits.

The magnitudes go through a two-stage integrate-and-dump (CIC) filter. The filter decimates by eight, and its output is shifted back to nine bits, so a constant input gives the same value at the output. A runtime setting can add one more smoothing stage at the decimated rate, which narrows the detector bandwidth. That stage averages the newest decimated value with either the value just before it or the value four outputs back. Both options keep unity gain at DC.

A single-cycle strobe marks each new estimate, one every eight clocks. Between strobes the estimate holds its value. The logarithmic mapping and the loop integration that use this estimate sit outside the block.

Top module: `agc_power_detect`

## Requirements
- R1: Only bits [13:4] of `sample_in`, read as a signed 10-bit value, affect the result; bits [3:0] are ignored.
- R2: The magnitude is the absolute value of that 10-bit slice, with the code -512 saturating to 511.
- R3: With a constant input held long enough, `power_out` equals the saturated magnitude from R2 (unity DC gain through the filter and the scaling by 2^-6).
- R4: `power_valid` is a one-cycle pulse that repeats exactly every 8 clocks.
- R5: With `comb_order` = 0 there is no extra stage: after a step between two constant levels, the 4th and every later strobe carry the new level.
- R6: With `comb_order` = 1 each output is (c[n] + c[n-1]) >> 1, where c is the decimated filter sequence; after a step, the 5th strobe carries the new level.
- R7: With `comb_order` = 2 each output is (c[n] + c[n-4]) >> 1; after a step from a settled level A to B, the 4th strobe carries (A+B)>>1 and the 8th carries B.
- R8: The code `comb_order` = 3 behaves the same as code 0.
- R9: `power_out` changes only in a cycle where `power_valid` is high.
- R10: Reset clears all integrator, comb, history and counter state: during reset `power_out` = 0 and `power_valid` = 0, and with zero input after reset the first estimate is 0.
- R11: The integrators wrap modulo 2^16, so a full-scale input held for any length of time keeps giving 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 14 | Signed input sample; bits [13:4] are used |
| comb_order | input | 2 | Extra smoothing: 0 none, 1 one-back average, 2 four-back average, 3 same as 0 |
| power_out | output | 9 | Unsigned power estimate at clock/8 |
| power_valid | output | 1 | One-cycle strobe for each new estimate |

## Verification
The behaviour that is hardest to reach from the ports is the transient of the extra smoothing stage. Its history only shows in the output while the CIC output is changing, and the CIC output settles within three strobes. The stimulus therefore first holds one level for twelve strobes so that the filter and its history are settled. It then steps to a second level right after a strobe and reads a chosen strobe after the step. Under order 2 that strobe gives the exact midpoint of the two levels, and under orders 0, 1 and 3 it gives the new level.

// File: rtl/agc_det_pkg.sv
package agc_det_pkg;
    localparam int SAMPLE_W = 14;
    localparam int SLICE_LSB = 4;
    localparam int SLICE_W = SAMPLE_W - SLICE_LSB;
    localparam int EST_W = 9;
    localparam int DECIM = 8;
    localparam int CIC_STAGES = 2;
    localparam int HIST_LEN = 4;

    typedef enum logic [1:0] {
        ORD_NONE = 2'd0,
        ORD_ONE  = 2'd1,
        ORD_FOUR = 2'd2,
        ORD_RSVD = 2'd3
    } comb_ord_e;
endpackage

// File: rtl/agc_rectifier.sv
module agc_rectifier #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  din,
    output logic [OUT_W-1:0]        mag
);
    localparam int MAXV = (1 << OUT_W) - 1;

    typedef struct packed {
        logic [OUT_W-1:0] mag;
    } rect_st_t;

    rect_st_t st_d, st_q;
    logic signed [IN_W:0] sx;
    logic [IN_W:0]        wide;

    always_comb begin
        st_d = st_q;
        sx   = {din[IN_W-1], din};
        wide = sx[IN_W] ? $unsigned(-sx) : $unsigned(sx);
        if (wide > (IN_W+1)'(MAXV)) begin
            st_d.mag = OUT_W'(MAXV);
        end else begin
            st_d.mag = wide[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mag = st_q.mag;

    // R2: a non-negative slice passes straight through one register
    a_r2_positive_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !din[IN_W-1] |=> (mag == OUT_W'($past(din))));
endmodule

// File: rtl/agc_cic_decim.sv
module agc_cic_decim #(
    parameter int IN_W   = 9,
    parameter int OUT_W  = 9,
    parameter int DEC    = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   din,
    output logic [OUT_W-1:0]  dout,
    output logic              dvalid
);
    localparam int CNT_W  = $clog2(DEC);
    localparam int GROWTH = STAGES * CNT_W;
    localparam int ACC_W  = IN_W + GROWTH + 1;
    localparam int SHIFT  = IN_W + GROWTH - OUT_W;

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] integ;
        logic [STAGES-1:0][ACC_W-1:0] dly;
        logic [CNT_W-1:0]             cnt;
        logic [OUT_W-1:0]             dout;
        logic                         valid;
    } cic_st_t;

    cic_st_t          st_d, st_q;
    logic [ACC_W-1:0] v;
    logic             tick;

    always_comb begin
        st_d = st_q;
        v    = '0;
        st_d.integ[0] = st_q.integ[0] + ACC_W'(din);
        for (int s = 1; s < STAGES; s++) begin
            st_d.integ[s] = st_q.integ[s] + st_q.integ[s-1];
        end
        tick       = (st_q.cnt == CNT_W'(DEC - 1));
        st_d.cnt   = tick ? '0 : st_q.cnt + 1'b1;
        st_d.valid = tick;
        if (tick) begin
            v = st_q.integ[STAGES-1];
            for (int s = 0; s < STAGES; s++) begin
                st_d.dly[s] = v;
                v = v - st_q.dly[s];
            end
            st_d.dout = v[SHIFT +: OUT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout   = st_q.dout;
    assign dvalid = st_q.valid;

    // R4: the decimated strobe never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> !dvalid);
endmodule

// File: rtl/agc_post_comb.sv
module agc_post_comb
    import agc_det_pkg::*;
#(
    parameter int W   = 9,
    parameter int DLY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic          din_valid,
    input  logic [1:0]    order,
    output logic [W-1:0]  dout,
    output logic          dout_valid
);
    typedef struct packed {
        logic [DLY-1:0][W-1:0] hist;
        logic [W-1:0]          out;
        logic                  valid;
    } post_st_t;

    post_st_t   st_d, st_q;
    comb_ord_e  ord;
    logic [W-1:0] tap;
    logic [W:0]   sum;

    always_comb begin
        st_d  = st_q;
        ord   = comb_ord_e'(order);
        tap   = (ord == ORD_ONE) ? st_q.hist[0] : st_q.hist[DLY-1];
        sum   = {1'b0, din} + {1'b0, tap};
        st_d.valid = din_valid;
        if (din_valid) begin
            st_d.hist[0] = din;
            for (int i = 1; i < DLY; i++) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
            case (ord)
                ORD_ONE, ORD_FOUR: st_d.out = sum[W:1];
                default:           st_d.out = din;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout       = st_q.out;
    assign dout_valid = st_q.valid;

    // R5: with no extra stage the decimated value passes through unchanged
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && order == 2'd0) |=> (dout == $past(din)));
endmodule

// File: rtl/agc_power_detect.sv
module agc_power_detect
    import agc_det_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SAMPLE_W-1:0]  sample_in,
    input  logic [1:0]           comb_order,
    output logic [EST_W-1:0]     power_out,
    output logic                 power_valid
);
    logic [EST_W-1:0] mag;
    logic [EST_W-1:0] cic_val;
    logic             cic_vld;

    agc_rectifier #(.IN_W(SLICE_W), .OUT_W(EST_W)) u_rect (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ($signed(sample_in[SAMPLE_W-1:SLICE_LSB])),
        .mag   (mag)
    );

    agc_cic_decim #(.IN_W(EST_W), .OUT_W(EST_W), .DEC(DECIM), .STAGES(CIC_STAGES)) u_cic (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (mag),
        .dout   (cic_val),
        .dvalid (cic_vld)
    );

    agc_post_comb #(.W(EST_W), .DLY(HIST_LEN)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (cic_val),
        .din_valid  (cic_vld),
        .order      (comb_order),
        .dout       (power_out),
        .dout_valid (power_valid)
    );

    // Checker state: cycles since the last strobe
    logic [7:0] since_v;
    logic       seen_v;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_v <= '0;
            seen_v  <= 1'b0;
        end else if (power_valid) begin
            since_v <= '0;
            seen_v  <= 1'b1;
        end else begin
            since_v <= since_v + 1'b1;
        end
    end

    // R4: strobes are exactly DECIM clocks apart
    a_r4_period: assert property (@(posedge clk) disable iff (!rst_n)
        (power_valid && seen_v) |-> (since_v == 8'(DECIM - 1)));

    // R9: the estimate holds between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !power_valid |-> $stable(power_out));
endmodule

// File: tb/tb_agc_power_detect.sv
module tb_agc_power_detect;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 11;

    typedef struct packed {
        logic [1:0]  ord;
        logic [13:0] a;
        logic [13:0] b;
        logic [7:0]  k;
        logic [9:0]  exp;
    } vec_t;

    // ord, level A sample, level B sample, strobes after step, expected value
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 14'(0),          14'(100*16),      8'd4, 10'd100},  // R5
        '{2'd0, 14'(300*16),     14'(-200*16+9),   8'd4, 10'd200},  // R5 R2
        '{2'd1, 14'(50*16),      14'(400*16),      8'd5, 10'd400},  // R6
        '{2'd1, 14'(-16),        14'(7*16+3),      8'd5, 10'd7},    // R6
        '{2'd2, 14'(0),          14'(100*16),      8'd4, 10'd50},   // R7
        '{2'd2, 14'(100*16),     14'(-300*16),     8'd4, 10'd200},  // R7
        '{2'd2, 14'(100*16),     14'(-300*16),     8'd8, 10'd300},  // R7
        '{2'd2, 14'(3*16),       14'(6*16),        8'd4, 10'd4},    // R7 floor
        '{2'd3, 14'(10*16),      14'(-512*16),     8'd4, 10'd511},  // R8 R2
        '{2'd0, 14'(511*16),     14'(-511*16+15),  8'd4, 10'd511},  // R2
        '{2'd0, 14'(100*16),     14'(100*16+15),   8'd4, 10'd100}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] sample_in = '0;
    logic [1:0]  comb_order = '0;
    logic [8:0]  power_out;
    logic        power_valid;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agc_power_detect dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_in   (sample_in),
        .comb_order  (comb_order),
        .power_out   (power_out),
        .power_valid (power_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!power_valid);
    endtask

    task automatic wait_strobes(input int n);
        for (int i = 0; i < n; i++) wait_strobe();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int cnt;
        int prev;
        bit held;
        do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset power_out", int'(power_out), 0);
        check("R10 reset power_valid", int'(power_valid), 0);
        rst_n = 1'b1;

        // R4: exactly ten strobes in eighty clocks
        wait_strobe();
        cnt = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (power_valid) cnt++;
        end
        check("R4 strobe count", cnt, 10);

        // Table of step responses
        for (int v = 0; v < NVEC; v++) begin
            comb_order = VECS[v].ord;
            sample_in  = VECS[v].a;
            wait_strobes(12);
            sample_in  = VECS[v].b;
            wait_strobes(int'(VECS[v].k));
            check($sformatf("R3 R5 R6 R7 vector %0d", v), int'(power_out), int'(VECS[v].exp));
        end

        // R9: output holds between strobes
        comb_order = 2'd1;
        sample_in  = 14'(-250*16);
        wait_strobe();
        held = 1'b1;
        for (int i = 0; i < 40; i++) begin
            prev = int'(power_out);
            @(negedge clk);
            if (!power_valid && int'(power_out) != prev) held = 1'b0;
        end
        check("R9 hold between strobes", int'(held), 1);

        // R11: full scale for a long run, integrators wrap many times
        comb_order = 2'd0;
        sample_in  = 14'(-512*16);
        wait_strobes(200);
        check("R11 long full scale", int'(power_out), 511);

        // R3: settled mid-level under order 2
        comb_order = 2'd2;
        sample_in  = 14'(37*16+6);
        wait_strobes(12);
        check("R3 steady order2", int'(power_out), 37);

        // R10: reset mid-run clears state
        sample_in = 14'(400*16);
        wait_strobes(12);
        rst_n = 1'b0;
        sample_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wait_strobe();
        check("R10 first estimate after reset", int'(power_out), 0);
        wait_strobes(4);
        check("R10 zero after reset order2", int'(power_out), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule